// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Request/Acknowledge Hand-off

This block receives asynchronous serial bytes on one input line. Each frame is an idle-high line, a low start bit, eight data bits with the least significant bit first, and a high stop bit. The system clock is divided into a sampling tick that runs at eight times the bit rate. With the default divider of 651, a 50 MHz clock gives a tick of about 76.8 kHz and a rate of 9600 baud. The line passes through a two-flop synchronizer. A control state machine then drives a sample counter, a bit counter and a shift register, and these place each bit at its middle.

When a frame ends with a valid stop bit, the block puts the byte on `data` and raises `req`. It then holds both values until the consumer pulses `ack`. While `req` is high the receiver ignores the line, so a byte that is waiting can never be overwritten. A consumer, such as a processor port, reads the byte, finds the valid flag in `req`, and pulses `ack` once it has taken the byte.

Top module: `uart_hs_rx`

## Requirements
- R1: A sampling tick occurs once every `CLK_PER_TICK` clocks. One bit lasts `OVS` ticks. From a start edge to the rise of `req`, a frame takes about (OVS/2 + 9·OVS − 1) tick periods plus the synchronizer delay.
- R2: `rcv` goes through two flops before use. The data bits are taken at mid-bit and assembled least significant bit first, so the first data bit on the line becomes `data[0]`.
- R3: A low pulse on an idle line that is shorter than half a bit time starts no frame. The receiver returns to idle and then accepts the next real frame.
- R4: `req` rises, and `data` takes the received byte, only when the stop bit is sampled high.
- R5: If the stop bit is sampled low, the frame is dropped. `req` stays low and `data` keeps its earlier value. If the line then stays low, no frame starts until the line has gone high and fallen again.
- R6: While `req` is high, `data` and `req` stay unchanged until `ack` is sampled high. `req` is low on the next clock after that.
- R7: Frames that arrive while `req` is high are ignored, so the waiting byte is not overwritten.
- R8: `ack` has no effect while `req` is low.
- R9: Synchronous active-high reset clears `req` and `data` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rcv | input | 1 | Asynchronous serial line, idle high |
| ack | input | 1 | Consumer has taken the byte |
| req | output | 1 | A received byte is waiting |
| data | output | DATA_W | The byte that is waiting |

## Verification
The hardest case to reach is a whole frame that arrives while an earlier byte is still unacknowledged. Only this case shows that the hold state drops the line instead of overwriting the byte. The bench sends one byte, sends a second byte without acknowledging the first, and then acknowledges. It checks that the first byte survives and that the second byte never appears. The other case is a stop bit held low for several bit times. The bench drives it and then sends a clean frame, to show that the receiver waits for a new falling edge.

// File: rtl/uart_hs_rx_pkg.sv
package uart_hs_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rx_state_t;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV = 651
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_sync2.sv
module rx_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta     <= 1'b1;
      sync_out <= 1'b1;
    end else begin
      meta     <= async_in;
      sync_out <= meta;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_hs_rx_pkg::*;
#(
  parameter int OVS    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx,
  input  logic              ack,
  output logic              req,
  output logic [DATA_W-1:0] data
);
  localparam int SW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF = OVS / 2;

  rx_state_t         st;
  logic [SW-1:0]     samp;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              rx_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      samp  <= '0;
      bitn  <= '0;
      shreg <= '0;
      data  <= '0;
      req   <= 1'b0;
      rx_d  <= 1'b1;
    end else begin
      rx_d <= rx;
      case (st)
        ST_IDLE: begin
          if (rx_d && !rx) begin
            st   <= ST_START;
            samp <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (samp == SW'(HALF - 1)) begin
              samp <= '0;
              bitn <= '0;
              st   <= rx ? ST_IDLE : ST_DATA;
            end else begin
              samp <= samp + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (samp == SW'(OVS - 1)) begin
              samp  <= '0;
              shreg <= {rx, shreg[DATA_W-1:1]};
              if (bitn == BW'(DATA_W - 1)) st <= ST_STOP;
              else bitn <= bitn + 1'b1;
            end else begin
              samp <= samp + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (samp == SW'(OVS - 1)) begin
              samp <= '0;
              if (rx) begin
                data <= shreg;
                req  <= 1'b1;
                st   <= ST_HOLD;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              samp <= samp + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (ack) begin
            req <= 1'b0;
            st  <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_hs_rx.sv
module uart_hs_rx #(
  parameter int CLK_PER_TICK = 651,
  parameter int OVS          = 8,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rcv,
  input  logic              ack,
  output logic              req,
  output logic [DATA_W-1:0] data
);
  logic tick;
  logic rx_s;

  rx_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rx_sync2 u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (rcv),
    .sync_out (rx_s)
  );

  rx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .rx   (rx_s),
    .ack  (ack),
    .req  (req),
    .data (data)
  );
endmodule

// File: rtl/uart_hs_rx_chk.sv
module uart_hs_rx_chk #(
  parameter int CLK_PER_TICK = 651,
  parameter int DATA_W       = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic              req,
  input logic [DATA_W-1:0] data,
  input logic              rx_s,
  input logic              tick
);
  localparam int GW = $clog2(CLK_PER_TICK + 1) + 1;

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  assert_tick_period_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && seen) |-> (gap == GW'(CLK_PER_TICK - 1)));

  assert_req_needs_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(rx_s));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);

  assert_data_held_R7: assert property (@(posedge clk) disable iff (rst)
    req |=> (data == $past(data)));

  assert_idle_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (!req && ack) |=> $stable(data));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!req && data == '0));
endmodule

bind uart_hs_rx uart_hs_rx_chk #(.CLK_PER_TICK(CLK_PER_TICK), .DATA_W(DATA_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .ack  (ack),
  .req  (req),
  .data (data),
  .rx_s (rx_s),
  .tick (tick)
);

// File: tb/test_uart_hs_rx.sv
module test_uart_hs_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int OVS        = 8;
  localparam int W          = 8;
  localparam int BIT        = DIV * OVS;
  localparam int NVEC       = 7;
  // each entry: {stop bit level, byte}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h155, 9'h1A3, 9'h100, 9'h1FF, 9'h080, 9'h13C, 9'h101
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rcv = 1'b1;
  logic         ack = 1'b0;
  logic         req;
  logic [W-1:0] data;
  int           n_tests = 0;
  int           n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_hs_rx #(.CLK_PER_TICK(DIV), .OVS(OVS), .DATA_W(W)) i_uart_hs_rx (
    .clk  (clk),
    .rst  (rst),
    .rcv  (rcv),
    .ack  (ack),
    .req  (req),
    .data (data)
  );

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] b, input logic stop_v, input int extra_low);
    @(negedge clk) rcv = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      rcv = b[i];
      repeat (BIT) @(negedge clk);
    end
    rcv = stop_v;
    repeat (BIT + extra_low) @(negedge clk);
    rcv = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [W-1:0] last_good;
    int           cnt;
    last_good = '0;
    repeat (5) @(negedge clk);
    check("R9 req after reset", int'(req), 0);
    check("R9 data after reset", int'(data), 0);
    rst = 1'b0;
    repeat (BIT) @(negedge clk);

    // R8: ack while nothing waits
    pulse_ack();
    repeat (3) @(negedge clk);
    check("R8 req after idle ack", int'(req), 0);
    check("R8 data after idle ack", int'(data), 0);

    // table walk: R2, R4, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][7:0], VEC[v][8], 0);
      check("R4/R5 req after frame", int'(req), int'(VEC[v][8]));
      check("R2 data after frame", int'(data), VEC[v][8] ? int'(VEC[v][7:0]) : int'(last_good));
      if (VEC[v][8]) begin
        last_good = VEC[v][7:0];
        repeat (20) @(negedge clk);
        check("R6 req held", int'(req), 1);
        check("R6 data held", int'(data), int'(last_good));
        pulse_ack();
        check("R6 req falls after ack", int'(req), 0);
      end
    end

    // R3: glitch shorter than half a bit
    @(negedge clk) rcv = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    rcv = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check("R3 glitch no req", int'(req), 0);
    send(8'h5A, 1'b1, 0);
    check("R3 frame after glitch", int'(data), 'h5A);
    pulse_ack();

    // R7: frame arriving while a byte waits
    send(8'h11, 1'b1, 0);
    send(8'h22, 1'b1, 0);
    check("R7 req still high", int'(req), 1);
    check("R7 data not overwritten", int'(data), 'h11);
    pulse_ack();
    repeat (2 * BIT) @(negedge clk);
    check("R7 dropped frame gives no req", int'(req), 0);
    check("R7 data kept after ack", int'(data), 'h11);

    // R5: stop held low for three extra bits
    send(8'h99, 1'b0, 3 * BIT);
    check("R5 long low stop no req", int'(req), 0);
    check("R5 data unchanged", int'(data), 'h11);
    send(8'h77, 1'b1, 0);
    check("R5 recovery frame", int'(data), 'h77);
    pulse_ack();

    // R1: latency from start edge to req
    cnt = 0;
    fork
      send(8'hC5, 1'b1, 0);
      begin
        @(negedge clk);
        while (!req && cnt < 2000) begin
          @(negedge clk);
          cnt++;
        end
      end
    join
    check("R1 latency in window", int'(cnt >= 296 && cnt <= 316), 1);
    check("R1 data", int'(data), 'hC5);
    pulse_ack();

    report();
  end
endmodule